// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for software that stops servicing it. It counts ticks of the internal RC oscillator. A fixed prescaler of 2^PRE_BITS ticks is followed by three cascaded divide-by-8 stages. Two select bits pick the prescaler output or the output of one of the stages as the timeout interval. Each interval is therefore eight times the one below it. With the default prescaler and a 16 MHz RC clock, the shortest interval is 256 µs.

Timeout handling has two stages. When the selected interval elapses, the interrupt flag is set, and an interrupt is requested if the interrupt enable is high. A reset delay of DLY_TICKS RC ticks then starts. If software has not restarted the timer when the delay ends, and the reset enable is high, the block emits a one-cycle system reset pulse and sets a sticky reset flag. A restart strobe clears the chain and cancels a pending reset. The block also drives a request that keeps the RC oscillator running while either enable is set, even when the system clock has moved to an external source.

Everything runs in the system clock domain. The RC clock arrives as a single-cycle tick enable, `rc_tick`. The default prescaler width of 12 can be reduced through a parameter so that simulations stay short.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `irq_flag`, `irq_req`, `rst_flag` and `wd_reset` are all 0.
- R2: Only clock edges with `rc_tick` high advance the timer. The Nth such edge after a restart sets `irq_flag`, where N = 2^(PRE_BITS + 3*sel).
- R3: Select codes 0, 1, 2 and 3 give intervals in the ratio 1:8:64:512. Code 3 equals the full counter span, 2^(PRE_BITS+9) ticks.
- R4: `irq_req` is high exactly when `irq_flag` is set and `irq_en` is 1. The flag itself is set on timeout whatever the state of `irq_en`.
- R5: On the DLY_TICKS-th tick edge after the edge that started the delay, with `rst_en` = 1, `wd_reset` is high for exactly one clock cycle and `rst_flag` becomes 1.
- R6: With `rst_en` = 0, the end of the reset delay produces neither a reset pulse nor `rst_flag`.
- R7: A `restart` strobe clears the interval counter and cancels a running reset delay, so the old deadline produces no reset.
- R8: Any change of `sel` restarts the counter in the same way as `restart`. The new interval is then counted from that edge.
- R9: `irq_flag` and `rst_flag` stay set until `irq_clr` or `rst_clr` respectively is high at a clock edge. A timeout at the same edge keeps the flag set.
- R10: `rc_keep_on` is high whenever `irq_en` or `rst_en` is 1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_tick | input | 1 | One-cycle enable per RC oscillator period |
| sel | input | SW (2) | Interval select: 2^(PRE_BITS+3*sel) ticks |
| irq_en | input | 1 | Interrupt request enable |
| rst_en | input | 1 | Reset output enable |
| restart | input | 1 | Software restart strobe |
| irq_clr | input | 1 | Clears the interrupt flag |
| rst_clr | input | 1 | Clears the reset flag |
| irq_flag | output | 1 | Sticky timeout flag |
| irq_req | output | 1 | Interrupt request |
| rst_flag | output | 1 | Sticky watchdog-reset flag |
| wd_reset | output | 1 | One-cycle system reset pulse |
| rc_keep_on | output | 1 | Keeps the RC oscillator enabled |

## Verification
The hardest case to reach is a restart that lands inside the reset delay, after the interrupt has been raised but before the reset deadline. Only this case shows whether the old deadline was really cancelled rather than just delayed. The bench lets a short interval expire, strobes restart a few cycles into the delay while clearing the flags, and then expects one new interrupt and one reset, both timed from the restart. A reset left over from the old deadline arrives at a cycle with no matching scoreboard entry and is caught. A second hard case is an interval change made after the counter has passed the new, shorter tap. The bench triggers it by switching from code 2 to code 1 two hundred ticks into an interval.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int PRE_BITS  = 12,
  parameter int STG_BITS  = 3,
  parameter int SW        = 2,
  parameter int DLY_TICKS = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rc_tick,
  input  logic [SW-1:0] sel,
  input  logic          irq_en,
  input  logic          rst_en,
  input  logic          restart,
  input  logic          irq_clr,
  input  logic          rst_clr,
  output logic          irq_flag,
  output logic          irq_req,
  output logic          rst_flag,
  output logic          wd_reset,
  output logic          rc_keep_on
);
  localparam int NSTG = (1 << SW) - 1;
  localparam int CW   = PRE_BITS + NSTG * STG_BITS;
  localparam int DW   = $clog2(DLY_TICKS);

  logic [CW-1:0] cnt;
  logic [DW-1:0] dly;
  logic          dly_run;
  logic [SW-1:0] sel_q;
  logic [CW:0]   tap_oh;
  logic [CW-1:0] tap_end;
  logic          clr_all, timeout, dly_end, fire;

  assign tap_oh  = {{CW{1'b0}}, 1'b1} << (PRE_BITS + STG_BITS * int'(sel));
  assign tap_end = CW'(tap_oh - 1'b1);
  assign clr_all = restart || (sel != sel_q);
  assign timeout = rc_tick && (cnt == tap_end);
  assign dly_end = rc_tick && dly_run && (dly == DW'(DLY_TICKS - 1));
  assign fire    = dly_end && rst_en;

  assign irq_req    = irq_flag && irq_en;
  assign rc_keep_on = irq_en || rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dly      <= '0;
      dly_run  <= 1'b0;
      sel_q    <= '0;
      wd_reset <= 1'b0;
      irq_flag <= 1'b0;
      rst_flag <= 1'b0;
    end else begin
      sel_q    <= sel;
      wd_reset <= 1'b0;
      if (clr_all) begin
        cnt     <= '0;
        dly     <= '0;
        dly_run <= 1'b0;
      end else begin
        if (fire)         cnt <= '0;
        else if (rc_tick) cnt <= timeout ? '0 : cnt + 1'b1;

        if (dly_end) begin
          dly_run <= 1'b0;
          dly     <= '0;
        end else if (rc_tick && dly_run) begin
          dly <= dly + 1'b1;
        end else if (timeout) begin
          dly_run <= 1'b1;
          dly     <= '0;
        end
        wd_reset <= fire;
      end
      irq_flag <= (timeout && !clr_all) || (irq_flag && !irq_clr);
      rst_flag <= (fire && !clr_all) || (rst_flag && !rst_clr);
    end
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic rc_tick,
  input logic rst_en,
  input logic restart,
  input logic rst_clr,
  input logic irq_flag,
  input logic rst_flag,
  input logic wd_reset
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);
  a_r5_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> rst_flag);
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> $past(rst_en));
  a_r7_restart_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wd_reset);
  a_r9_sticky_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !rst_clr) |=> rst_flag);
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(rc_tick));
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .rst_en(rst_en),
  .restart(restart), .rst_clr(rst_clr), .irq_flag(irq_flag),
  .rst_flag(rst_flag), .wd_reset(wd_reset)
);

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int PRE = 2;
  localparam int DLY = 16;

  logic clk = 1'b0, rst_n = 1'b0, rc_tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic irq_en = 0, rst_en = 0, restart = 0, irq_clr = 0, rst_clr = 0;
  logic irq_flag, irq_req, rst_flag, wd_reset, rc_keep_on;

  wdog_two_stage #(.PRE_BITS(PRE), .STG_BITS(3), .SW(2), .DLY_TICKS(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .sel(sel), .irq_en(irq_en),
    .rst_en(rst_en), .restart(restart), .irq_clr(irq_clr), .rst_clr(rst_clr),
    .irq_flag(irq_flag), .irq_req(irq_req), .rst_flag(rst_flag),
    .wd_reset(wd_reset), .rc_keep_on(rc_keep_on));

  always #2 clk = ~clk;

  typedef struct { int kind; int at; string tag; } ev_t;
  ev_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int ph = 0, tick_m = 1;
  bit tick_on = 0, done = 0, irq_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int kind, int at, string tag);
    ev_t e; e.kind = kind; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    rc_tick = tick_on && (ph == 0);
    ph = (ph + 1) % tick_m;
    restart = 0; irq_clr = 0; rst_clr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic do_restart(output int c0);
    @(negedge clk);
    restart = 1; irq_clr = 1; rst_clr = 1; rc_tick = 0; ph = 0;
    c0 = cyc;
  endtask

  // monitor: compare observed events against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_flag && !irq_prev) check_ev(0);
      if (wd_reset) check_ev(1);
      irq_prev = irq_flag;
    end
  end

  task automatic check_ev(int kind);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, kind == 0 ? "R2 unexpected interrupt" : "R7 unexpected reset", cyc, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind && e.at == cyc, e.tag, cyc, e.at);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    idle(3);
    rst_n = 1;
    step();
    chk(irq_flag == 0 && rst_flag == 0, "R1 flags after reset", {irq_flag, rst_flag}, 0);
    chk(irq_req == 0 && wd_reset == 0, "R1 outputs after reset", {irq_req, wd_reset}, 0);
    chk(rc_keep_on == 0, "R10 keep-on with both enables low", rc_keep_on, 0);
    irq_en = 1; step();
    chk(rc_keep_on == 1, "R10 keep-on with interrupt enable", rc_keep_on, 1);
    irq_en = 0; rst_en = 1; step();
    chk(rc_keep_on == 1, "R10 keep-on with reset enable", rc_keep_on, 1);

    // interval code 0, tick every cycle, both enables: interrupt then reset
    tick_on = 1; tick_m = 1; sel = 0; irq_en = 1; rst_en = 1;
    do_restart(c0);
    push(0, c0 + 5, "R2 code 0 interrupt timing");
    push(1, c0 + 5 + DLY, "R5 reset after delay");
    idle(5 + DLY);
    chk(rst_flag == 1, "R5 reset flag set", rst_flag, 1);
    chk(irq_req == 1, "R4 request with enable", irq_req, 1);
    step();
    chk(wd_reset == 0, "R5 pulse lasts one cycle", wd_reset, 0);
    chk(rst_flag == 1 && irq_flag == 1, "R9 flags sticky", {irq_flag, rst_flag}, 3);
    do_restart(c0);
    step();
    chk(irq_flag == 0 && rst_flag == 0, "R9 flags cleared", {irq_flag, rst_flag}, 0);

    // interval code 1, sparse ticks, enables off
    tick_m = 3; sel = 1; irq_en = 0; rst_en = 0;
    do_restart(c0);
    push(0, c0 + 2 + 31 * 3, "R2 code 1 with sparse ticks");
    idle(1 + 31 * 3 + DLY * 3 + 8);
    chk(irq_flag == 1, "R4 flag set without enable", irq_flag, 1);
    chk(irq_req == 0, "R4 no request without enable", irq_req, 0);
    chk(rst_flag == 0, "R6 no reset flag without enable", rst_flag, 0);

    // restart inside the reset delay cancels the old deadline
    tick_m = 1; sel = 0; irq_en = 1; rst_en = 1;
    do_restart(c0);
    push(0, c0 + 5, "R7 first interrupt");
    idle(10);
    do_restart(c1);
    push(0, c1 + 5, "R7 interrupt after restart");
    push(1, c1 + 5 + DLY, "R7 reset timed from restart");
    idle(5 + DLY);
    chk(rst_flag == 1, "R7 reset flag after new delay", rst_flag, 1);
    step();

    // interval change after passing the shorter tap
    rst_en = 0; sel = 2;
    do_restart(c0);
    idle(199);
    step(); sel = 1; c1 = cyc;
    push(0, c1 + 33, "R8 select change restarts");
    idle(40);
    chk(irq_flag == 1, "R8 flag after new interval", irq_flag, 1);

    // longest tap
    sel = 3;
    do_restart(c0);
    push(0, c0 + 2 + 2047, "R3 code 3 spans 512 base intervals");
    idle(2050);
    chk(irq_flag == 1, "R3 flag after longest interval", irq_flag, 1);
    do_restart(c0);
    tick_on = 0;
    idle(5);
    chk(q.size() == 0, "R2 all expected events seen", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule